// File: doc/BRIEF.md
# Skip-Pattern Program Sequencer

This block holds the program counter of a small in-order core that runs from local instruction memory, together with a mask that can cancel upcoming instructions. A skip operation loads a pattern with one bit per following instruction. A 1 cancels that instruction and a 0 lets it run. The combined jump-with-mask and call-with-mask operations take a single 32-bit register operand. Its low ten bits give the branch target and its upper 22 bits give the mask, so one register value is enough to select a routine and trim it. The call form also saves a return address on a small internal stack.

Cancelled instructions do not cost execute cycles. When the sequencer moves the program counter, it also steps over up to eight consecutive cancelled slots in the same cycle. Only a longer run of cancelled instructions shows up as a cancelled slot at the output. The block also follows a hardware loop that wraps back to the loop top. In external-fetch mode that wrap uses up one extra mask bit, because there it is carried out as a jump.

Top module: `pc_skip_seq`

## Requirements
- R1: After reset the program counter is 0, the execute flag is 1 and the return stack is empty (depth 0).
- R2: An executed non-branch instruction with no active mask moves the program counter to PC+1 with the execute flag 1. In a cycle with no issue strobe the program counter and the execute flag hold.
- R3: A skip operation (opcode 1) loads operand[21:0] as the mask. Bit 0 applies to the instruction right after the skip. A 1 bit cancels that instruction, and the execute flag always describes the instruction at the current program counter.
- R4: In a single cycle the program counter steps past up to 8 consecutive cancelled instructions. If more remain, the next slot is presented with execute flag 0 and uses one issue cycle.
- R5: An instruction issued in a cancelled slot has no effect beyond advancing one position. A cancelled jump does not branch and a cancelled call does not push.
- R6: The jump-with-mask operation (opcode 2) branches to {base, operand[9:0]}, which is (base << 10) + operand[9:0]. It loads operand[31:10] as the mask, with bit 0 applying to the target instruction.
- R7: The call-with-mask operation (opcode 3) behaves like opcode 2 and also pushes PC+1. A return (opcode 5) pops that address into the program counter.
- R8: A plain jump (opcode 4) sets the program counter to operand[13:0] and clears any active mask.
- R9: Loading a new mask replaces any mask that is still active, including with an all-zero mask.
- R10: The return stack holds 8 entries and the depth output saturates at 8. A push into a full stack overwrites the oldest entry. A pop from an empty stack returns address 0 and the depth stays 0.
- R11: On a loop wrap the program counter goes to the loop top. In local mode the wrap uses up one mask bit. In external-fetch mode it uses up two.
- R12: Opcode 0 denotes any non-branch instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | The instruction at pc_o issues this cycle |
| issue_op | input | 3 | Class of the issued instruction (0 plain, 1 skip, 2 jump-with-mask, 3 call-with-mask, 4 jump, 5 return) |
| issue_operand | input | 32 | Register operand of the issued instruction |
| ext_base | input | 4 | Base value placed above the 10-bit target of masked branches |
| ext_mode | input | 1 | 1 when code is fetched from external memory |
| loop_wrap | input | 1 | The issued instruction is the last one of a hardware loop body |
| loop_top | input | 14 | Address of the first instruction of the loop body |
| pc_o | output | 14 | Address of the instruction to issue next |
| exec_o | output | 1 | 1 if the instruction at pc_o executes, 0 if it is cancelled |
| rs_depth_o | output | 4 | Number of valid return-stack entries |

## Verification
Two cases are hard to reach from the ports. The first is a cancelled slot that is still presented at the output. It only appears after a run of more than eight ones, so the bench loads ten-bit and nine-bit runs of ones. It then issues a jump and a call into the cancelled slot and watches the program counter and the stack depth. The second is the difference between the two loop-wrap modes. Here the bench places a single 1 a few bits up in the mask, so the extra bit used up in external mode moves that 1 under the next instruction. The two modes then land on program counters one apart.

// File: rtl/pc_skip_pkg.sv
package pc_skip_pkg;
  localparam int OPND_W = 32;
  localparam int TGT_W  = 10;
  localparam int PAT_W  = OPND_W - TGT_W;

  typedef enum logic [2:0] {
    OP_PLAIN = 3'd0,
    OP_SKIP  = 3'd1,
    OP_JSKIP = 3'd2,
    OP_CSKIP = 3'd3,
    OP_JUMP  = 3'd4,
    OP_RET   = 3'd5
  } issue_op_e;
endpackage

// File: rtl/skip_hop.sv
module skip_hop #(
  parameter int PC_W    = 14,
  parameter int PAT_W   = 22,
  parameter int MAX_HOP = 8
) (
  input  logic [PC_W-1:0]  raw_pc,
  input  logic [PAT_W-1:0] raw_pat,
  output logic [PC_W-1:0]  hop_pc,
  output logic [PAT_W-1:0] hop_pat
);
  localparam int HOP_W = $clog2(MAX_HOP + 1);

  logic [HOP_W-1:0] run_len;
  logic             in_run;

  // count the trailing ones of the mask, but stop at MAX_HOP
  always_comb begin
    in_run  = 1'b1;
    run_len = '0;
    for (int i = 0; i < MAX_HOP; i++) begin
      if (in_run && raw_pat[i]) run_len = run_len + 1'b1;
      else                      in_run  = 1'b0;
    end
  end

  assign hop_pc  = raw_pc + PC_W'(run_len);
  assign hop_pat = raw_pat >> run_len;
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 8,
  parameter int DW    = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [DW-1:0]            push_addr,
  input  logic                     pop,
  output logic [DW-1:0]            pop_addr,
  output logic [$clog2(DEPTH+1)-1:0] depth
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    slots [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty;

  assign empty    = (cnt_q == '0);
  assign pop_addr = empty ? '0 : slots[wp_q - 1'b1];
  assign depth    = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    cnt_d = cnt_q;
    if (push) begin
      wp_d = wp_q + 1'b1;
      if (cnt_q != CNT_W'(DEPTH)) cnt_d = cnt_q + 1'b1;
    end else if (pop && !empty) begin
      wp_d  = wp_q - 1'b1;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wp_q] <= push_addr;
  end

  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  p_push_grows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push && (cnt_q < CNT_W'(DEPTH)) |=> cnt_q == $past(cnt_q) + 1'b1);

  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && empty |=> cnt_q == '0);
endmodule

// File: rtl/pc_skip_seq.sv
module pc_skip_seq
  import pc_skip_pkg::*;
#(
  parameter int BASE_W   = 4,
  parameter int MAX_HOP  = 8,
  parameter int RS_DEPTH = 8,
  localparam int PC_W    = TGT_W + BASE_W,
  localparam int DEPTH_W = $clog2(RS_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_valid,
  input  logic [2:0]          issue_op,
  input  logic [OPND_W-1:0]   issue_operand,
  input  logic [BASE_W-1:0]   ext_base,
  input  logic                ext_mode,
  input  logic                loop_wrap,
  input  logic [PC_W-1:0]     loop_top,
  output logic [PC_W-1:0]     pc_o,
  output logic                exec_o,
  output logic [DEPTH_W-1:0]  rs_depth_o
);
  logic [PC_W-1:0]  pc_q, pc_d, raw_pc, hop_pc, ret_addr, skip_tgt;
  logic [PAT_W-1:0] pat_q, pat_d, raw_pat, hop_pat;
  logic             live, do_push, do_pop;
  issue_op_e        op;

  assign op       = issue_op_e'(issue_op);
  assign live     = !pat_q[0];
  assign skip_tgt = {ext_base, issue_operand[TGT_W-1:0]};

  // position and mask before the run of cancelled slots is stepped over
  always_comb begin
    raw_pc  = pc_q + 1'b1;
    raw_pat = pat_q >> 1;
    do_push = 1'b0;
    do_pop  = 1'b0;
    if (loop_wrap) begin
      raw_pc  = loop_top;
      raw_pat = ext_mode ? (pat_q >> 2) : (pat_q >> 1);
    end
    if (issue_valid && live) begin
      case (op)
        OP_SKIP:  raw_pat = issue_operand[PAT_W-1:0];
        OP_JSKIP: begin
          raw_pc  = skip_tgt;
          raw_pat = issue_operand[OPND_W-1:TGT_W];
        end
        OP_CSKIP: begin
          raw_pc  = skip_tgt;
          raw_pat = issue_operand[OPND_W-1:TGT_W];
          do_push = 1'b1;
        end
        OP_JUMP: begin
          raw_pc  = issue_operand[PC_W-1:0];
          raw_pat = '0;
        end
        OP_RET: begin
          raw_pc = ret_addr;
          do_pop = 1'b1;
        end
        default: ;
      endcase
    end
  end

  skip_hop #(.PC_W(PC_W), .PAT_W(PAT_W), .MAX_HOP(MAX_HOP)) i_hop (
    .raw_pc  (raw_pc),
    .raw_pat (raw_pat),
    .hop_pc  (hop_pc),
    .hop_pat (hop_pat)
  );

  ret_stack #(.DEPTH(RS_DEPTH), .DW(PC_W)) i_rs (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (do_push),
    .push_addr (pc_q + 1'b1),
    .pop       (do_pop),
    .pop_addr  (ret_addr),
    .depth     (rs_depth_o)
  );

  assign pc_d  = issue_valid ? hop_pc  : pc_q;
  assign pat_d = issue_valid ? hop_pat : pat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      pat_q <= '0;
    end else begin
      pc_q  <= pc_d;
      pat_q <= pat_d;
    end
  end

  assign pc_o   = pc_q;
  assign exec_o = live;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> $stable(pc_o) && $stable(exec_o) && $stable(rs_depth_o));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && exec_o && (issue_op == 3'd0) && !loop_wrap && !pat_q[1]
    |=> (pc_o == $past(pc_o) + 1'b1) && exec_o);

  p_jump_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && exec_o && (issue_op == 3'd4)
    |=> exec_o && (pc_o == $past(issue_operand[PC_W-1:0])));

  p_cancel_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !exec_o |=> $stable(rs_depth_o));
endmodule

// File: tb/test_pc_skip_seq.sv
module test_pc_skip_seq;
  localparam int CLK_P = 10;
  localparam int PC_W  = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [2:0]  issue_op;
  logic [31:0] issue_operand;
  logic [3:0]  ext_base;
  logic        ext_mode;
  logic        loop_wrap;
  logic [PC_W-1:0] loop_top;
  logic [PC_W-1:0] pc_o;
  logic        exec_o;
  logic [3:0]  rs_depth_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  pc_skip_seq i_pc_skip_seq (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_operand(issue_operand), .ext_base(ext_base), .ext_mode(ext_mode),
    .loop_wrap(loop_wrap), .loop_top(loop_top), .pc_o(pc_o), .exec_o(exec_o),
    .rs_depth_o(rs_depth_o)
  );

  task automatic chk(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic state(string req, int epc, int eexec, int edep);
    chk(req, "pc", int'(pc_o), epc);
    chk(req, "exec", int'(exec_o), eexec);
    chk(req, "depth", int'(rs_depth_o), edep);
  endtask

  task automatic issue(int op, logic [31:0] opnd, bit wrap = 0);
    @(negedge clk);
    issue_valid   = 1'b1;
    issue_op      = op[2:0];
    issue_operand = opnd;
    loop_wrap     = wrap;
    @(negedge clk);
    issue_valid = 1'b0;
    loop_wrap   = 1'b0;
  endtask

  task automatic t_reset;
    state("R1", 0, 1, 0);
  endtask

  task automatic t_plain;
    issue(0, 0);
    state("R2", 1, 1, 0);
    @(negedge clk);
    state("R2", 1, 1, 0);
  endtask

  task automatic t_skip;
    issue(1, 32'b0101);
    state("R3", 3, 1, 0);
    issue(0, 0);
    state("R3", 5, 1, 0);
  endtask

  task automatic t_long_run;
    issue(1, 32'h3FF);
    state("R4", 14, 0, 0);
    issue(4, 32'h100);          // cancelled jump, R5
    state("R5", 16, 1, 0);
    issue(1, 32'h1FF);
    state("R4", 25, 0, 0);
    issue(3, 32'h040);          // cancelled call, R5
    state("R5", 26, 1, 0);
  endtask

  task automatic t_jskip;
    issue(2, (32'b110 << 10) | 32'h040);
    state("R6", 'h40, 1, 0);
    issue(0, 0);
    state("R6", 'h43, 1, 0);
    ext_base = 4'd2;
    issue(2, 32'h005);
    state("R6", 'h805, 1, 0);
    ext_base = 4'd0;
  endtask

  task automatic t_call;
    issue(3, (32'b1 << 10) | 32'h200);
    state("R7", 'h201, 1, 1);
    issue(5, 0);
    state("R7", 'h806, 1, 0);
  endtask

  task automatic t_jump_clear;
    issue(1, 32'b10);
    state("R8", 'h807, 1, 0);
    issue(4, 32'h0123);
    state("R8", 'h123, 1, 0);
    issue(0, 0);
    state("R8", 'h124, 1, 0);
  endtask

  task automatic t_replace;
    issue(1, 32'hE);
    state("R9", 'h125, 1, 0);
    issue(1, 32'h0);
    state("R9", 'h126, 1, 0);
    issue(0, 0);
    state("R9", 'h127, 1, 0);
  endtask

  task automatic t_stack;
    for (int k = 0; k < 9; k++) issue(3, 32'h300 + 2*k);
    state("R10", 'h310, 1, 8);
    for (int i = 0; i < 8; i++) begin
      issue(5, 0);
      state("R10", 'h300 + 2*(8-i) - 1, 1, 7-i);
    end
    issue(5, 0);
    state("R10", 0, 1, 0);
    issue(5, 0);
    state("R10", 0, 1, 0);
  endtask

  task automatic t_loop;
    loop_top = 14'h10;
    ext_mode = 1'b0;
    issue(1, 32'b0100);
    state("R11", 1, 1, 0);
    issue(0, 0, 1);
    state("R11", 'h10, 1, 0);
    issue(0, 0);
    state("R11", 'h12, 1, 0);
    ext_mode = 1'b1;
    issue(1, 32'b0100);
    state("R11", 'h13, 1, 0);
    issue(0, 0, 1);
    state("R11", 'h11, 1, 0);
    issue(0, 0);
    state("R12", 'h12, 1, 0);
    ext_mode = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; issue_valid = 1'b0; issue_op = '0; issue_operand = '0;
    ext_base = '0; ext_mode = 1'b0; loop_wrap = 1'b0; loop_top = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_skip();
    t_long_run();
    t_jskip();
    t_call();
    t_jump_clear();
    t_replace();
    t_stack();
    t_loop();
    finish_run();
  end
endmodule